// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two groups of data pins, called the A side and the B side. It is split into a number of independent lanes, each one byte wide. Each direction, A toward B and B toward A, keeps its own bank of storage. Each direction also has its own active-low controls in every lane:

- a direction enable,
- a load control,
- an output enable.

Each direction also has one active-low clear that acts on every lane at once.

The block does not drive tri-state pins itself. For each side it produces a data bus and a per-lane drive flag, and an external pad buffer uses these. A per-lane clash flag is raised when both sides of the same lane would be driven at the same moment.

Storage is built as clock-sampled registers rather than true level-sensitive latches:

- While a lane is open (direction enable and load control both low), the stored byte follows the near-side input at every clock edge.
- When either control goes high, the byte held is the one sampled at the last open edge.
- The far-side bus shows the stored byte whenever the lane is driven, and shows zero otherwise.

Top module: `latch_xcvr`

## Requirements
- R1: At a clock edge where a lane's A-to-B direction enable and load control are both low, that lane's A-to-B store takes the lane's byte from `a_in`. When driven, `b_out` shows that byte from just after the edge.
- R2: At a clock edge where either of those two controls is high, the lane's store keeps its previous value, whatever `a_in` does.
- R3: Loading does not depend on the output enable. A byte loaded while the far side is not driven appears on the bus once the output enable goes low.
- R4: `b_drive[i]` is high exactly when `ab_en_n[i]` and `ab_oe_n[i]` are both low, with no clock delay. While `b_drive[i]` is low, lane i of `b_out` reads zero.
- R5: A low `ab_rst_n` clears every lane's A-to-B store to zero at once, without waiting for a clock, and takes priority over loading. The B-to-A stores are not affected.
- R6: After the clear is released, a store holds zero until its lane is next opened.
- R7: Each lane obeys only its own controls. Opening one lane leaves the other lanes' stores unchanged.
- R8: `clash[i]` is high exactly when `a_drive[i]` and `b_drive[i]` are both high.
- R9: The B-to-A direction behaves as in R1 to R6, using `ba_en_n`, `ba_le_n`, `ba_oe_n`, `ba_rst_n`, `b_in`, `a_out` and `a_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| ab_rst_n | input | 1 | Active-low asynchronous clear of all A-to-B stores |
| ba_rst_n | input | 1 | Active-low asynchronous clear of all B-to-A stores |
| ab_en_n | input | LANES | Active-low A-to-B direction enable, one bit per lane |
| ab_le_n | input | LANES | Active-low A-to-B load control, one bit per lane |
| ab_oe_n | input | LANES | Active-low A-to-B output enable, one bit per lane |
| ba_en_n | input | LANES | Active-low B-to-A direction enable, one bit per lane |
| ba_le_n | input | LANES | Active-low B-to-A load control, one bit per lane |
| ba_oe_n | input | LANES | Active-low B-to-A output enable, one bit per lane |
| a_in | input | LANES*WIDTH | A-side input data; lane i is bits [i*WIDTH +: WIDTH] |
| b_in | input | LANES*WIDTH | B-side input data; same lane layout |
| b_out | output | LANES*WIDTH | Data to drive onto the B side |
| b_drive | output | LANES | B-side pad drive enable, one bit per lane |
| a_out | output | LANES*WIDTH | Data to drive onto the A side |
| a_drive | output | LANES | A-side pad drive enable, one bit per lane |
| clash | output | LANES | Both sides of the lane driven at once |

## Verification
The bench builds the block with its defaults, two lanes of eight bits. Two lanes are enough to show that one lane's controls leave its neighbour alone, and that the clash flag is tracked per lane. Eight-bit random data makes an accidental match between a stale byte and a fresh one unlikely. Random controls with rare clears reach every combination of the enable, load and output-enable bits in both directions. Directed phases pin down loading while the far side is not driven, a clear raised between clock edges, and the hold at zero after a clear is released.

// File: rtl/latch_xcvr_pkg.sv
package latch_xcvr_pkg;

    localparam int unsigned XCVR_LANES = 2;
    localparam int unsigned XCVR_WIDTH = 8;

    // A path is open when both of its active-low qualifiers are low.
    function automatic logic path_open(input logic gate_n, input logic ctl_n);
        return (!gate_n) && (!ctl_n);
    endfunction

endpackage

// File: rtl/latch_xcvr_bank.sv
module latch_xcvr_bank
    import latch_xcvr_pkg::*;
#(
    parameter int unsigned LANES = XCVR_LANES,
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       en_n,
    input  logic [LANES-1:0]       le_n,
    input  logic [LANES-1:0]       oe_n,
    input  logic [LANES*WIDTH-1:0] din,
    output logic [LANES*WIDTH-1:0] dout,
    output logic [LANES-1:0]       drive,
    output logic [LANES*WIDTH-1:0] store
);
    localparam int unsigned BITS = LANES * WIDTH;

    typedef struct packed {
        logic [BITS-1:0] data;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LANES; i++) begin
            if (path_open(en_n[i], le_n[i])) begin
                st_d.data[i*WIDTH +: WIDTH] = din[i*WIDTH +: WIDTH];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign drive[g] = path_open(en_n[g], oe_n[g]);
        assign dout[g*WIDTH +: WIDTH] = drive[g] ? st_q.data[g*WIDTH +: WIDTH] : '0;
    end

    assign store = st_q.data;

endmodule

// File: rtl/latch_xcvr_clash.sv
module latch_xcvr_clash #(
    parameter int unsigned LANES = 2
) (
    input  logic [LANES-1:0] fwd_drive,
    input  logic [LANES-1:0] rev_drive,
    output logic [LANES-1:0] clash
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign clash[g] = fwd_drive[g] & rev_drive[g];
    end
endmodule

// File: rtl/latch_xcvr.sv
module latch_xcvr
    import latch_xcvr_pkg::*;
#(
    parameter int unsigned LANES = XCVR_LANES,
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic                   clk,
    input  logic                   ab_rst_n,
    input  logic                   ba_rst_n,
    input  logic [LANES-1:0]       ab_en_n,
    input  logic [LANES-1:0]       ab_le_n,
    input  logic [LANES-1:0]       ab_oe_n,
    input  logic [LANES-1:0]       ba_en_n,
    input  logic [LANES-1:0]       ba_le_n,
    input  logic [LANES-1:0]       ba_oe_n,
    input  logic [LANES*WIDTH-1:0] a_in,
    input  logic [LANES*WIDTH-1:0] b_in,
    output logic [LANES*WIDTH-1:0] b_out,
    output logic [LANES-1:0]       b_drive,
    output logic [LANES*WIDTH-1:0] a_out,
    output logic [LANES-1:0]       a_drive,
    output logic [LANES-1:0]       clash
);
    logic [LANES*WIDTH-1:0] ab_store;
    logic [LANES*WIDTH-1:0] ba_store;

    latch_xcvr_bank #(.LANES(LANES), .WIDTH(WIDTH)) u_ab (
        .clk   (clk),
        .rst_n (ab_rst_n),
        .en_n  (ab_en_n),
        .le_n  (ab_le_n),
        .oe_n  (ab_oe_n),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drive),
        .store (ab_store)
    );

    latch_xcvr_bank #(.LANES(LANES), .WIDTH(WIDTH)) u_ba (
        .clk   (clk),
        .rst_n (ba_rst_n),
        .en_n  (ba_en_n),
        .le_n  (ba_le_n),
        .oe_n  (ba_oe_n),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drive),
        .store (ba_store)
    );

    latch_xcvr_clash #(.LANES(LANES)) u_clash (
        .fwd_drive (b_drive),
        .rev_drive (a_drive),
        .clash     (clash)
    );

endmodule

// File: rtl/latch_xcvr_chk.sv
module latch_xcvr_chk #(
    parameter int unsigned LANES = 2,
    parameter int unsigned WIDTH = 8
) (
    input logic                   clk,
    input logic                   ab_rst_n,
    input logic                   ba_rst_n,
    input logic [LANES-1:0]       ab_en_n,
    input logic [LANES-1:0]       ab_le_n,
    input logic [LANES-1:0]       ba_en_n,
    input logic [LANES-1:0]       ba_le_n,
    input logic [LANES*WIDTH-1:0] a_in,
    input logic [LANES*WIDTH-1:0] b_in,
    input logic [LANES*WIDTH-1:0] b_out,
    input logic [LANES*WIDTH-1:0] a_out,
    input logic [LANES-1:0]       b_drive,
    input logic [LANES-1:0]       a_drive,
    input logic [LANES-1:0]       clash,
    input logic [LANES*WIDTH-1:0] ab_store,
    input logic [LANES*WIDTH-1:0] ba_store
);
    // R5
    ab_clear_chk: assert property (@(posedge clk) !ab_rst_n |-> (ab_store == '0));
    // R9
    ba_clear_chk: assert property (@(posedge clk) !ba_rst_n |-> (ba_store == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R1
        ab_load_chk: assert property (@(posedge clk) disable iff (!ab_rst_n)
            (!ab_en_n[g] && !ab_le_n[g]) |=> (ab_store[g*WIDTH +: WIDTH] == $past(a_in[g*WIDTH +: WIDTH])));
        // R2
        ab_hold_chk: assert property (@(posedge clk) disable iff (!ab_rst_n)
            (ab_en_n[g] || ab_le_n[g]) |=> $stable(ab_store[g*WIDTH +: WIDTH]));
        // R9
        ba_load_chk: assert property (@(posedge clk) disable iff (!ba_rst_n)
            (!ba_en_n[g] && !ba_le_n[g]) |=> (ba_store[g*WIDTH +: WIDTH] == $past(b_in[g*WIDTH +: WIDTH])));
        // R4
        b_quiet_chk: assert property (@(posedge clk) disable iff (!ab_rst_n)
            !b_drive[g] |-> (b_out[g*WIDTH +: WIDTH] == '0));
        // R8
        clash_set_chk: assert property (@(posedge clk) disable iff (!ab_rst_n || !ba_rst_n)
            (a_drive[g] && b_drive[g]) |-> clash[g]);
        // R8
        clash_only_chk: assert property (@(posedge clk) disable iff (!ab_rst_n || !ba_rst_n)
            clash[g] |-> (a_drive[g] && b_drive[g]));
    end
endmodule

bind latch_xcvr latch_xcvr_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .ab_rst_n (ab_rst_n),
    .ba_rst_n (ba_rst_n),
    .ab_en_n  (ab_en_n),
    .ab_le_n  (ab_le_n),
    .ba_en_n  (ba_en_n),
    .ba_le_n  (ba_le_n),
    .a_in     (a_in),
    .b_in     (b_in),
    .b_out    (b_out),
    .a_out    (a_out),
    .b_drive  (b_drive),
    .a_drive  (a_drive),
    .clash    (clash),
    .ab_store (ab_store),
    .ba_store (ba_store)
);

// File: tb/latch_xcvr_test.sv
`timescale 1ns/1ps
module latch_xcvr_test;
    localparam int L = 2;
    localparam int W = 8;

    logic clk = 1'b0;
    logic ab_rst_n, ba_rst_n;
    logic [L-1:0] ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
    logic [L*W-1:0] a_in, b_in;
    logic [L*W-1:0] b_out, a_out;
    logic [L-1:0] b_drive, a_drive, clash;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_ab [L];
    logic [W-1:0] m_ba [L];

    always #5 clk = ~clk;

    latch_xcvr #(.LANES(L), .WIDTH(W)) uut (
        .clk(clk), .ab_rst_n(ab_rst_n), .ba_rst_n(ba_rst_n),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_in(a_in), .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .a_out(a_out), .a_drive(a_drive), .clash(clash)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] shown(input logic [W-1:0] st, input logic en_n, input logic oe_n);
        return (!en_n && !oe_n) ? st : '0;
    endfunction

    task automatic model_clear();
        if (!ab_rst_n) for (int i = 0; i < L; i++) m_ab[i] = '0;
        if (!ba_rst_n) for (int i = 0; i < L; i++) m_ba[i] = '0;
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < L; i++) begin
            chk({tag, " data b_out"}, 32'(b_out[i*W +: W]), 32'(shown(m_ab[i], ab_en_n[i], ab_oe_n[i])));
            chk({tag, " data a_out"}, 32'(a_out[i*W +: W]), 32'(shown(m_ba[i], ba_en_n[i], ba_oe_n[i])));
            chk("R4 b_drive", 32'(b_drive[i]), 32'(!ab_en_n[i] && !ab_oe_n[i]));
            chk("R4 R9 a_drive", 32'(a_drive[i]), 32'(!ba_en_n[i] && !ba_oe_n[i]));
            chk("R8 clash", 32'(clash[i]),
                32'((!ab_en_n[i] && !ab_oe_n[i]) && (!ba_en_n[i] && !ba_oe_n[i])));
        end
    endtask

    // Called just after a falling edge with inputs already set.
    task automatic tick(input string tag);
        @(posedge clk);
        model_clear();
        for (int i = 0; i < L; i++) begin
            if (ab_rst_n && !ab_en_n[i] && !ab_le_n[i]) m_ab[i] = a_in[i*W +: W];
            if (ba_rst_n && !ba_en_n[i] && !ba_le_n[i]) m_ba[i] = b_in[i*W +: W];
        end
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        ab_rst_n = 1'b0; ba_rst_n = 1'b0;
        ab_en_n = '0; ab_le_n = '1; ab_oe_n = '0;
        ba_en_n = '0; ba_le_n = '1; ba_oe_n = '1;
        a_in = 16'hA55A; b_in = 16'h3CC3;
        for (int i = 0; i < L; i++) begin m_ab[i] = '0; m_ba[i] = '0; end
        @(negedge clk);
        tick("R5 reset");
        tick("R5 reset");
        // R5: the clear wins over an open lane
        ab_le_n = '0; ba_le_n = '0;
        tick("R5 priority");
        ab_rst_n = 1'b1; ba_rst_n = 1'b1;
        ab_le_n = '1; ba_le_n = '1;
        ab_oe_n = '0; ba_oe_n = '1;
        // R6: hold zero after release
        tick("R6 hold zero");
        tick("R6 hold zero");

        // R3: load while not driven, then show
        ab_oe_n = '1; ab_le_n = '0; a_in = 16'h5AC7;
        tick("R3 load hidden");
        ab_le_n = '1; a_in = 16'h0000;
        tick("R3 R2 hold hidden");
        ab_oe_n = '0;
        tick("R3 show");

        // R7: lane 0 open, lane 1 closed
        ab_le_n = 2'b10; a_in = 16'h9E21;
        tick("R7 lane0 open");
        ab_le_n = 2'b01; a_in = 16'h4400;
        tick("R7 lane1 open");
        // R2: enable high closes the path even with load low
        ab_en_n = '1; ab_le_n = '0; a_in = 16'hFFFF;
        tick("R2 enable closed");
        ab_en_n = '0; ab_le_n = '1;
        tick("R2 kept");

        // R9: B-to-A path with clash
        ba_en_n = '0; ba_oe_n = '0; ba_le_n = '0; b_in = 16'h6B19;
        tick("R9 R8 open");
        ba_le_n = '1; b_in = 16'h0F0F;
        tick("R9 held");

        // R5: clear between clock edges, no clock needed
        #2;
        ab_rst_n = 1'b0;
        #1;
        model_clear();
        compare_all("R5 async");
        @(negedge clk);
        tick("R5 async other side kept");
        ab_rst_n = 1'b1;
        tick("R6 after async");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            ab_en_n = 2'($urandom_range(0, 3) == 0 ? 3 : $urandom);
            ab_le_n = 2'($urandom);
            ab_oe_n = 2'($urandom);
            ba_en_n = 2'($urandom_range(0, 3) == 0 ? 3 : $urandom);
            ba_le_n = 2'($urandom);
            ba_oe_n = 2'($urandom);
            a_in = 16'($urandom);
            b_in = 16'($urandom);
            ab_rst_n = ($urandom_range(0, 40) != 0);
            ba_rst_n = ($urandom_range(0, 40) != 0);
            #1;
            model_clear();
            tick("R1 R2 R9 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule